// File: doc/BRIEF.md
# Nonlinear-Ratio External Clock Divider

This block derives an external clock from a fixed 96 MHz base clock. A 16-bit control word holds a 6-bit ratio selector. The selector maps to a divisor in a non-linear way: between 2 and 8 it steps by one, and above 8 it steps by two up to 96, so no odd divisor above 8 can be produced. The divided clock runs only when the enable bit is set and the source bit selects the base clock. An invert bit makes the output rest high while the divider is stopped.

A second, purely combinational path takes a requested output rate in hertz. It returns the divisor that software should program and the selector code for that divisor. The divisor chosen is the smallest usable one whose output rate, truncated to whole hertz, does not exceed the request. Software has two ways to change the control word. A full write replaces the whole word. A ratio write changes only the selector, forces the base-clock source and keeps the other bits.

Top module: `ext_clk_ratio_div`

## Requirements
- R1: After reset the control word reads 0x0000 and `clk_out` is low.
- R2: Control word fields: bit 0 is the source select (0 = base clock), bit 1 is the run enable, bits [7:2] are the selector S, bit 8 is the invert, and bits [15:9] are plain storage. For S of 6 or less the divisor is S+2. For S above 6 the divisor is 8+2*(S-6).
- R3: A selector that would give a divisor above 96 (S > 50) produces divisor 96.
- R4: For an even divisor D the output is high for D/2 base cycles and low for D/2 base cycles. For D equal to 3, 5 or 7 the high phase is (D+1)/2 cycles and the low phase is (D-1)/2 cycles.
- R5: A full write (`cfg_wr`, which wins over `sel_wr`) loads all 16 bits. A ratio write loads bits [7:2] from `sel_wdata`, clears bit 0, and keeps bit 1 and bits [15:8]. `cfg_rdata` always shows the current word.
- R6: The divider runs only while bit 1 is 1 and bit 0 is 0. Otherwise `clk_out` stays at its idle level.
- R7: The idle level is the value of bit 8. While running, the waveform of R4 is inverted when bit 8 is 1.
- R8: A selector change made while running takes effect only after the current output period has completed.
- R9: `req_div` is the first divisor D, scanning upward from 2 and skipping odd values above 8, for which floor(96000000/D) <= `req_rate`. If no such D exists, `req_div` is 96.
- R10: `req_sel` encodes `req_div` as D-2 for D up to 8 and as (D-8)/2+6 for D above 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 96 MHz base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Full control-word write strobe |
| cfg_wdata | input | 16 | Full control-word write data |
| sel_wr | input | 1 | Ratio-only write strobe |
| sel_wdata | input | 6 | Selector value for a ratio write |
| cfg_rdata | output | 16 | Current control word |
| req_rate | input | 32 | Requested output rate in Hz |
| req_sel | output | 6 | Selector code for the computed divisor |
| req_div | output | 7 | Computed divisor |
| clk_out | output | 1 | Divided clock output |

## Verification
The divider is run with selectors for divisors 2, 3, 7, 8, 10 and 96, and with a clamped selector. Each setting shows a distinct high/low phase pair, so a wrong branch of the mapping, a wrong odd-duty rule or a missing clamp each produces a different wrong period. One run changes the selector partway through a period, which separates a change applied at the period boundary from one applied at once. The rate helper is given exact quotients, values just below a quotient, a rate that falls in the gap left by the skipped odd divisors, and rates too low for any divisor; these show the scan direction, the odd-divisor skip and the fallback.

// File: rtl/ext_clk_ratio_div.sv
module ext_clk_ratio_div #(
  parameter int BASE_HZ = 96_000_000,
  parameter int MIN_DIV = 2,
  parameter int LIN_MAX = 8,
  parameter int MAX_DIV = 96,
  parameter int RATE_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [15:0]       cfg_wdata,
  input  logic              sel_wr,
  input  logic [5:0]        sel_wdata,
  output logic [15:0]       cfg_rdata,
  input  logic [RATE_W-1:0] req_rate,
  output logic [5:0]        req_sel,
  output logic [6:0]        req_div,
  output logic              clk_out
);
  localparam int DIV_W   = $clog2(MAX_DIV + 1);
  localparam int LIN_SEL = LIN_MAX - MIN_DIV;

  function automatic logic [DIV_W-1:0] sel_to_div(input logic [5:0] s);
    int d;
    if (int'(s) <= LIN_SEL) d = int'(s) + MIN_DIV;
    else d = LIN_MAX + 2 * (int'(s) - LIN_SEL);
    if (d > MAX_DIV) d = MAX_DIV;
    return DIV_W'(d);
  endfunction

  logic [15:0]      ctrl;
  logic [DIV_W-1:0] cnt, cur_div, div_sel;
  logic [DIV_W:0]   hi_len;
  logic             started, phase, run;

  assign cfg_rdata = ctrl;
  assign run       = ctrl[1] & ~ctrl[0];
  assign div_sel   = sel_to_div(ctrl[7:2]);
  assign hi_len    = ({1'b0, cur_div} + 1'b1) >> 1;
  assign clk_out   = phase ^ ctrl[8];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ctrl <= '0;
    else if (cfg_wr) ctrl <= cfg_wdata;
    else if (sel_wr) ctrl <= {ctrl[15:8], sel_wdata, ctrl[1], 1'b0};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt     <= '0;
      cur_div <= DIV_W'(MIN_DIV);
      started <= 1'b0;
      phase   <= 1'b0;
    end else if (!run) begin
      cnt     <= '0;
      cur_div <= div_sel;
      started <= 1'b0;
      phase   <= 1'b0;
    end else if (!started || cnt == cur_div - 1'b1) begin
      cnt     <= '0;
      cur_div <= div_sel;
      started <= 1'b1;
      phase   <= 1'b1;
    end else begin
      cnt     <= cnt + 1'b1;
      phase   <= ({1'b0, cnt} + 1'b1) < hi_len;
    end

  logic [DIV_W-1:0] pick;
  logic             found;
  always_comb begin
    pick  = DIV_W'(MAX_DIV);
    found = 1'b0;
    for (int d = MIN_DIV; d <= MAX_DIV; d++) begin
      if (!found && !((d % 2 == 1) && d > LIN_MAX) &&
          (64'(BASE_HZ) < (64'(req_rate) + 64'd1) * 64'(d))) begin
        found = 1'b1;
        pick  = DIV_W'(d);
      end
    end
  end

  assign req_div = 7'(pick);
  assign req_sel = (int'(pick) <= LIN_MAX) ? 6'(int'(pick) - MIN_DIV)
                                           : 6'((int'(pick) - LIN_MAX) / 2 + LIN_SEL);
endmodule

module ext_clk_ratio_div_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic [15:0] cfg_wdata,
  input logic        sel_wr,
  input logic [5:0]  sel_wdata,
  input logic [15:0] cfg_rdata,
  input logic [5:0]  req_sel,
  input logic [6:0]  req_div,
  input logic        clk_out,
  input logic [6:0]  cnt,
  input logic [6:0]  cur_div
);
  // R5
  full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> cfg_rdata == $past(cfg_wdata));
  // R5
  ratio_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && !cfg_wr) |=> (cfg_rdata[0] == 1'b0) && (cfg_rdata[7:2] == $past(sel_wdata)) &&
      (cfg_rdata[1] == $past(cfg_rdata[1])) && (cfg_rdata[15:8] == $past(cfg_rdata[15:8])));
  // R6
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_rdata[1] && !cfg_rdata[0]) |=> clk_out == cfg_rdata[8]);
  // R4
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < cur_div);
  // R3
  div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_div >= 7'd2 && cur_div <= 7'd96 && req_div >= 7'd2 && req_div <= 7'd96);
  // R10
  sel_encode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_div <= 7'd8) ? (7'(req_sel) == req_div - 7'd2)
                      : (!req_div[0] && 7'(req_sel) == (req_div - 7'd8) / 2 + 7'd6));
endmodule

bind ext_clk_ratio_div ext_clk_ratio_div_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
  .sel_wr(sel_wr), .sel_wdata(sel_wdata), .cfg_rdata(cfg_rdata),
  .req_sel(req_sel), .req_div(req_div), .clk_out(clk_out),
  .cnt(cnt), .cur_div(cur_div));

// File: tb/ext_clk_ratio_div_test.sv
module ext_clk_ratio_div_test;
  logic        clk = 0, rst_n = 0;
  logic        cfg_wr = 0, sel_wr = 0;
  logic [15:0] cfg_wdata = 0;
  logic [5:0]  sel_wdata = 0;
  logic [15:0] cfg_rdata;
  logic [31:0] req_rate = 0;
  logic [5:0]  req_sel;
  logic [6:0]  req_div;
  logic        clk_out;

  int tests = 0, fails = 0, cycles = 0;
  int exp_hi_q[$], exp_lo_q[$];
  logic mon_arm = 0, mon_inv = 0;

  ext_clk_ratio_div uut (.*);

  always #10 clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int div_of(input int s);
    int d = (s <= 6) ? s + 2 : 8 + 2 * (s - 6);
    return (d > 96) ? 96 : d;
  endfunction

  // monitor: measure complete high/low pairs and compare against scoreboard
  logic mprev = 0, mstarted = 0;
  int hi_c = 0, lo_c = 0;
  always @(negedge clk) begin
    if (!mon_arm) begin
      mprev = 0; mstarted = 0; hi_c = 0; lo_c = 0;
    end else begin
      logic o;
      o = clk_out ^ mon_inv;
      if (o && !mprev) begin
        if (mstarted) begin
          if (exp_hi_q.size() == 0) check("R4 unexpected period", hi_c, -1);
          else begin
            int eh, el;
            eh = exp_hi_q.pop_front();
            el = exp_lo_q.pop_front();
            check("R4 high phase", hi_c, eh);
            check("R4 low phase", lo_c, el);
          end
        end
        mstarted = 1; hi_c = 1; lo_c = 0;
      end else if (o) hi_c++;
      else if (mstarted) lo_c++;
      mprev = o;
    end
  end

  task automatic write_cfg(input logic [15:0] v);
    @(negedge clk); cfg_wr = 1; cfg_wdata = v;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic write_sel(input logic [5:0] s);
    @(negedge clk); sel_wr = 1; sel_wdata = s;
    @(negedge clk); sel_wr = 0;
  endtask

  task automatic push(input int sel, input int n);
    int d = div_of(sel);
    for (int i = 0; i < n; i++) begin
      exp_hi_q.push_back((d + 1) / 2);
      exp_lo_q.push_back(d / 2);
    end
  endtask

  task automatic drain(input string req);
    int w = 0;
    while (exp_hi_q.size() > 0 && w < 2000) begin @(negedge clk); w++; end
    check(req, exp_hi_q.size(), 0);
    exp_hi_q.delete(); exp_lo_q.delete();
  endtask

  task automatic run_div(input int sel, input logic inv, input int n, input string req);
    logic [15:0] base;
    base = {7'd0, inv, 6'(sel), 2'b00};
    write_cfg(base);
    mon_inv = inv; mon_arm = 1;
    push(sel, n);
    write_cfg(base | 16'h0002);
    drain(req);
    mon_arm = 0;
    write_cfg(base);
  endtask

  task automatic rate_chk(input int rate);
    int ed = 96;
    for (int d = 2; d <= 96; d++) begin
      if ((d % 2 == 1) && d > 8) continue;
      if (96000000 / d <= rate) begin ed = d; break; end
    end
    @(negedge clk); req_rate = rate; #1;
    check("R9 divisor", req_div, ed);
    check("R10 selector", req_sel, (ed <= 8) ? ed - 2 : (ed - 8) / 2 + 6);
  endtask

  initial begin
    while (cycles < 150000) begin @(posedge clk); cycles++; end
    fails++; tests++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset word", cfg_rdata, 0);
    check("R1 reset output", clk_out, 0);
    rst_n = 1;
    @(negedge clk);

    // R5 full write then ratio write
    write_cfg(16'hA503);
    check("R5 full write", cfg_rdata, 16'hA503);
    write_sel(6'h2A);
    check("R5 ratio write", cfg_rdata, 16'hA5AA);
    write_cfg(16'h0000);

    // R7 idle high when inverted and disabled
    write_cfg(16'h0100);
    repeat (5) begin @(negedge clk); check("R7 idle high", clk_out, 1); end
    // R6 enabled but alternate source selected: stays idle
    write_cfg(16'h0013);
    repeat (20) begin @(negedge clk); check("R6 held idle", clk_out, 0); end
    write_cfg(16'h0000);

    // R2 and R4 divisor patterns
    run_div(0, 0, 4, "R2 div2");
    run_div(1, 0, 4, "R4 div3");
    run_div(5, 0, 3, "R4 div7");
    run_div(6, 0, 3, "R2 div8");
    run_div(7, 0, 3, "R2 div10");
    run_div(50, 0, 2, "R2 div96");
    run_div(63, 0, 2, "R3 clamp");
    run_div(1, 1, 3, "R7 inverted");

    // R8: change selector mid period
    write_cfg(16'h0010);
    mon_inv = 0; mon_arm = 1;
    push(4, 2);
    write_cfg(16'h0012);
    drain("R8 before change");
    push(4, 1);
    push(2, 2);
    write_sel(6'd2);
    drain("R8 after change");
    mon_arm = 0;
    write_cfg(16'h0000);

    // R9 / R10 rate helper
    rate_chk(48000000);
    rate_chk(50000000);
    rate_chk(47999999);
    rate_chk(12000000);
    rate_chk(11000000);
    rate_chk(10666666);
    rate_chk(1000000);
    rate_chk(999999);
    rate_chk(0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule